// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Front End

This block sits beside an 8-bit processor core and turns five interrupt request inputs into at most one accepted request at a time. The inputs are a non-maskable trap, three maskable lines with fixed service addresses (called high, mid and low here), and a general request that carries no address of its own. When the core signals an instruction boundary, the block picks the highest-priority eligible request. It then reports that request to the core as a one-cycle pulse, together with the source and a 16-bit service address.

The general request is served through an acknowledge handshake. The block raises an acknowledge for one cycle. During that cycle the requesting device places a restart opcode on an input bus. The block turns the restart number in that opcode into a service address, which is a multiple of eight. The block also holds the global interrupt enable flag, which is set and cleared by enable and disable commands from the core, and a mask bit for each of the three vectored maskable lines.

The trap input and the high line are edge-captured. The mid line, the low line and the general request are level inputs that must still be asserted at the boundary where they are taken.

Top module: `irq_front`

## Requirements
- R1: After reset, take_o and gen_ack_o are 0, int_en_o is 0 and all three mask bits are set, so a low-line request is not taken even after an enable command.
- R2: A rising edge on trap_i is captured whatever the enable flag and masks hold. It is taken at the next boundary with take_src_o = 5'b10000 and address 16'h0024. A trap input that is held high is not taken a second time.
- R3: Fixed priority from highest to lowest is trap, high, mid, low, general. The take_src_o bit order is [4] trap, [3] high, [2] mid, [1] low, [0] general.
- R4: The high, mid and low lines are served at 16'h003C, 16'h0034 and 16'h002C respectively.
- R5: A rising edge on the high line is stored even while that line is masked. The stored request stays pending after the input falls, until it is taken or hi_pend_clr_i is pulsed.
- R6: The mid and low lines are level sensitive. A pulse that ends before the boundary is not taken.
- R7: A maskable line is eligible only while int_en_o = 1 and its mask bit is 0. mask_wr_i loads mask_i, where bit 0 is low, bit 1 is mid and bit 2 is high, and a 1 masks the line.
- R8: Taking any maskable request, including the general request, clears int_en_o on the same edge. Taking the trap leaves int_en_o unchanged.
- R9: A taken general request raises gen_ack_o for exactly one cycle, starting one clock after the boundary edge. The opcode 11nnn111 on rst_opc_i is sampled during that cycle, and the next cycle pulses take_o with take_src_o = 5'b00001 and address n*8.
- R10: A request is taken only on a clock edge where boundary_i = 1. For a vectored source, take_o pulses for one cycle, one clock after that edge.
- R11: en_set_i sets int_en_o and en_clr_i clears it, effective after the next edge. When both are given in the same cycle, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_i | input | 1 | Non-maskable trap request, edge captured |
| vec_hi_req_i | input | 1 | High-priority maskable line, edge captured |
| vec_mid_req_i | input | 1 | Mid-priority maskable line, level |
| vec_lo_req_i | input | 1 | Low-priority maskable line, level |
| gen_req_i | input | 1 | General non-vectored request, level |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| en_set_i | input | 1 | Enable command |
| en_clr_i | input | 1 | Disable command |
| mask_wr_i | input | 1 | Load the mask register |
| mask_i | input | 3 | New mask: bit0 low, bit1 mid, bit2 high; 1 = masked |
| hi_pend_clr_i | input | 1 | Drop a stored high-line request |
| rst_opc_i | input | 8 | Restart opcode supplied during the acknowledge |
| take_o | output | 1 | One-cycle pulse: request accepted |
| take_vec_o | output | 16 | Service address, valid with take_o |
| take_src_o | output | 5 | One-hot source, valid with take_o |
| gen_ack_o | output | 1 | Acknowledge for the general request |
| int_en_o | output | 1 | Global interrupt enable flag |

## Verification
The bench targets the cases where edge and level behaviour split:
- A trap input held high after service: a design that samples the level would take it again at every boundary.
- A high-line pulse that arrives while the line is masked: a design that gates capture with the mask would lose it.
- A high-line pulse followed by the clear input: a design that ignores the clear would still take it.
- A short mid-line pulse: a design that latches this line would take a request that is gone.

With all five sources asserted together, the bench drains them one boundary at a time to expose a wrong priority order. It also checks that the trap leaves the enable flag set while every maskable take clears it. The general-request handshake is checked for the one-cycle acknowledge, for the opcode sampling cycle, and for the restart-number-to-address mapping at both ends, 0000 and 0038, so a design with off-by-one sampling or a wrong bit field returns the wrong address.

// File: rtl/irq_front_pkg.sv
// Package: shared types and fixed service addresses for the interrupt front end.
// Assumes source index order [4] trap, [3] high, [2] mid, [1] low, [0] general.
package irq_front_pkg;

    localparam int SRC_N    = 5;
    localparam int SRC_TRAP = 4;
    localparam int SRC_HI   = 3;
    localparam int SRC_MID  = 2;
    localparam int SRC_LO   = 1;
    localparam int SRC_GEN  = 0;

    localparam int VEC_W = 16;
    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_HI   = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_MID  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;

    typedef enum logic {ST_IDLE, ST_ACK} fsm_t;

    // Map a one-hot grant of a hard-wired source to its service address.
    function automatic logic [VEC_W-1:0] fixed_vec(input logic [SRC_N-1:0] g);
        logic [VEC_W-1:0] v;
        v = '0;
        if (g[SRC_TRAP]) v = VEC_TRAP;
        if (g[SRC_HI])   v = VEC_HI;
        if (g[SRC_MID])  v = VEC_MID;
        if (g[SRC_LO])   v = VEC_LO;
        return v;
    endfunction

endpackage

// File: rtl/irq_edge_pend.sv
// Module: rising-edge capture with a sticky pending flag.
// Does: remembers the previous input level, sets the pending flag on a rising
// edge, and drops it on clr_i. A new edge in the same cycle as a clear wins.
// Assumes: lvl_i is synchronous to clk.
module irq_edge_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;

    // Track the previous level to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    // Sticky pending flag: an edge sets it, a clear drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (lvl_i && !prev_q)   pend_q <= 1'b1;
        else if (clr_i)              pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i && !prev_q) |=> pend_q);                               // R5
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);                               // R5

endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority one-hot picker; the highest index wins.
// Assumes: N >= 2.
module irq_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    // Each position is granted when no higher position requests.
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == N-1) begin : g_top
            assign grant_o[i] = req_i[i];
        end else begin : g_low
            assign grant_o[i] = req_i[i] & ~(|req_i[N-1:i+1]);
        end
    end

    assign any_o = |req_i;

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant_o));                 // R3
    end

endmodule

// File: rtl/irq_enable_regs.sv
// Module: global enable flag and per-line mask register.
// Does: the enable flag is cleared by reset, by an accepted maskable request
// and by the disable command, and set by the enable command, in that priority.
// Reset masks all lines.
module irq_enable_regs #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic             take_mask_i,
    input  logic             mask_wr_i,
    input  logic [LINES-1:0] mask_i,
    output logic             en_o,
    output logic [LINES-1:0] mask_o
);
    logic             en_q;
    logic [LINES-1:0] mask_q;

    // Enable flag: acceptance and disable dominate enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                   en_q <= 1'b0;
        else if (take_mask_i || clr_i) en_q <= 1'b0;
        else if (set_i)               en_q <= 1'b1;
    end

    // Mask register: all lines masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_wr_i) mask_q <= mask_i;
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !en_q);                                             // R11
    AST_TAKE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        take_mask_i |=> !en_q);                                       // R8

endmodule

// File: rtl/irq_front.sv
// Module: top of the prioritised vectored interrupt front end.
// Does: gathers eligible requests, picks one at each instruction boundary,
// and either reports a fixed service address or runs the acknowledge
// handshake to fetch a restart opcode for the general request.
// Assumes: all inputs synchronous to clk; the device answers an acknowledge
// with an opcode of form 11nnn111 in the same cycle.
module irq_front
    import irq_front_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OPC_W  = 8,
    parameter int RST_W  = 3,
    parameter int RST_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_i,
    input  logic              vec_hi_req_i,
    input  logic              vec_mid_req_i,
    input  logic              vec_lo_req_i,
    input  logic              gen_req_i,
    input  logic              boundary_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              mask_wr_i,
    input  logic [2:0]        mask_i,
    input  logic              hi_pend_clr_i,
    input  logic [OPC_W-1:0]  rst_opc_i,
    output logic              take_o,
    output logic [ADDR_W-1:0] take_vec_o,
    output logic [SRC_N-1:0]  take_src_o,
    output logic              gen_ack_o,
    output logic              int_en_o
);
    localparam int SLOT_SHIFT = 3;
    localparam int MASK_N     = 3;

    fsm_t              state_q;
    logic              take_q;
    logic              ack_q;
    logic [ADDR_W-1:0] vec_q;
    logic [SRC_N-1:0]  src_q;

    logic              trap_pend;
    logic              hi_pend;
    logic              en;
    logic [MASK_N-1:0] mask;
    logic [SRC_N-1:0]  elig;
    logic [SRC_N-1:0]  grant;
    logic              any_elig;
    logic              accept;
    logic              accept_mask;
    logic [ADDR_W-1:0] gen_vec;

    irq_edge_pend u_trap_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (trap_i),
        .clr_i  (accept && grant[SRC_TRAP]),
        .pend_o (trap_pend)
    );

    irq_edge_pend u_hi_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (vec_hi_req_i),
        .clr_i  ((accept && grant[SRC_HI]) || hi_pend_clr_i),
        .pend_o (hi_pend)
    );

    irq_enable_regs #(.LINES(MASK_N)) u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (en_set_i),
        .clr_i       (en_clr_i),
        .take_mask_i (accept_mask),
        .mask_wr_i   (mask_wr_i),
        .mask_i      (mask_i),
        .en_o        (en),
        .mask_o      (mask)
    );

    // Eligibility: trap ignores enable and masks; the rest need both.
    always_comb begin
        elig[SRC_TRAP] = trap_pend;
        elig[SRC_HI]   = hi_pend       & ~mask[2] & en;
        elig[SRC_MID]  = vec_mid_req_i & ~mask[1] & en;
        elig[SRC_LO]   = vec_lo_req_i  & ~mask[0] & en;
        elig[SRC_GEN]  = gen_req_i     & en;
    end

    irq_prio_pick #(.N(SRC_N)) u_pick (
        .req_i   (elig),
        .grant_o (grant),
        .any_o   (any_elig)
    );

    assign accept      = boundary_i && (state_q == ST_IDLE) && any_elig;
    assign accept_mask = accept && !grant[SRC_TRAP];
    assign gen_vec     = ADDR_W'({rst_opc_i[RST_LSB +: RST_W], {SLOT_SHIFT{1'b0}}});

    // Acceptance sequencer: fixed vectors report at once, general runs acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            take_q  <= 1'b0;
            ack_q   <= 1'b0;
            vec_q   <= '0;
            src_q   <= '0;
        end else begin
            take_q <= 1'b0;
            ack_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (grant[SRC_GEN]) begin
                            state_q <= ST_ACK;
                            ack_q   <= 1'b1;
                        end else begin
                            take_q <= 1'b1;
                            src_q  <= grant;
                            vec_q  <= ADDR_W'(fixed_vec(grant));
                        end
                    end
                end
                ST_ACK: begin
                    take_q  <= 1'b1;
                    src_q   <= SRC_N'(1) << SRC_GEN;
                    vec_q   <= gen_vec;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign take_o     = take_q;
    assign take_vec_o = vec_q;
    assign take_src_o = src_q;
    assign gen_ack_o  = ack_q;
    assign int_en_o   = en;

    AST_TAKE_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> ($countones(src_q) == 1));                         // R3
    AST_TRAP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (take_q && src_q[SRC_TRAP]) |-> (vec_q == 16'h0024));         // R2
    AST_MASKABLE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (take_q && |src_q[SRC_HI:SRC_LO]) |-> !en);                   // R8
    AST_ACK_THEN_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> (take_q && src_q[SRC_GEN] && !ack_q));              // R9
    AST_GEN_ADDR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_q && src_q[SRC_GEN]) |-> (vec_q[SLOT_SHIFT-1:0] == '0)); // R9
    AST_OPC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (rst_opc_i[7:6] == 2'b11 && rst_opc_i[2:0] == 3'b111)); // R9
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> ($past(boundary_i) || $past(ack_q)));              // R10

endmodule

// File: tb/irq_front_tb_top.sv
// Directed bench for irq_front: one task per scenario, each checking itself.
module irq_front_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap = 0, r_hi = 0, r_mid = 0, r_lo = 0, gen = 0;
    logic        bnd = 0, ei = 0, di = 0, mwr = 0, hclr = 0;
    logic [2:0]  mdat = 3'b000;
    logic [7:0]  opc = 8'hC7;
    logic        take, ack, ie;
    logic [15:0] vec;
    logic [4:0]  src;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_front dut_i (
        .clk(clk), .rst_n(rst_n), .trap_i(trap), .vec_hi_req_i(r_hi),
        .vec_mid_req_i(r_mid), .vec_lo_req_i(r_lo), .gen_req_i(gen),
        .boundary_i(bnd), .en_set_i(ei), .en_clr_i(di), .mask_wr_i(mwr),
        .mask_i(mdat), .hi_pend_clr_i(hclr), .rst_opc_i(opc),
        .take_o(take), .take_vec_o(vec), .take_src_o(src),
        .gen_ack_o(ack), .int_en_o(ie)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_bnd();
        bnd = 1'b1; tick(); bnd = 1'b0;
    endtask

    task automatic set_ie();
        ei = 1'b1; tick(); ei = 1'b0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        mwr = 1'b1; mdat = m; tick(); mwr = 1'b0;
    endtask

    task automatic expect_take(input string req, input logic [15:0] v, input logic [4:0] s);
        chk({req, " take"}, take, 1'b1);
        chk({req, " vec"}, vec, v);
        chk({req, " src"}, src, s);
    endtask

    task automatic t_reset();
        chk("R1 take", take, 0);
        chk("R1 ack", ack, 0);
        chk("R1 ie", ie, 0);
        set_ie();
        r_lo = 1'b1;
        pulse_bnd();
        chk("R1 masked after reset", take, 0);
        r_lo = 1'b0;
    endtask

    task automatic t_trap();
        trap = 1'b1; tick();
        pulse_bnd();
        expect_take("R2", 16'h0024, 5'b10000);
        chk("R8 trap keeps ie", ie, 1);
        tick();
        chk("R10 take one cycle", take, 0);
        pulse_bnd();
        chk("R2 held trap not retaken", take, 0);
        trap = 1'b0; tick();
    endtask

    task automatic t_vectors();
        set_mask(3'b000);
        r_lo = 1'b1; pulse_bnd();
        expect_take("R4 low", 16'h002C, 5'b00010);
        chk("R8 maskable clears ie", ie, 0);
        r_lo = 1'b0; set_ie();
        r_mid = 1'b1; pulse_bnd();
        expect_take("R4 mid", 16'h0034, 5'b00100);
        r_mid = 1'b0; set_ie();
        r_hi = 1'b1; tick(); r_hi = 1'b0; tick(); tick();
        pulse_bnd();
        expect_take("R4 R5 high after fall", 16'h003C, 5'b01000);
        set_ie();
    endtask

    task automatic t_edges_levels();
        r_mid = 1'b1; tick(); r_mid = 1'b0; tick();
        pulse_bnd();
        chk("R6 short mid pulse", take, 0);
        r_hi = 1'b1; tick(); r_hi = 1'b0; hclr = 1'b1; tick(); hclr = 1'b0;
        pulse_bnd();
        chk("R5 cleared high", take, 0);
        set_mask(3'b100);
        r_hi = 1'b1; tick(); r_hi = 1'b0; tick();
        pulse_bnd();
        chk("R7 high masked", take, 0);
        set_mask(3'b000);
        pulse_bnd();
        expect_take("R5 kept while masked", 16'h003C, 5'b01000);
        set_ie();
    endtask

    task automatic t_mask();
        set_mask(3'b010);
        r_mid = 1'b1; r_lo = 1'b1;
        pulse_bnd();
        expect_take("R7 mid masked", 16'h002C, 5'b00010);
        r_mid = 1'b0;
        di = 1'b1; tick(); di = 1'b0;
        pulse_bnd();
        chk("R7 ie off blocks", take, 0);
        r_lo = 1'b0;
        set_mask(3'b000);
        set_ie();
    endtask

    task automatic t_boundary();
        r_lo = 1'b1;
        repeat (5) tick();
        chk("R10 no boundary no take", take, 0);
        pulse_bnd();
        expect_take("R10 at boundary", 16'h002C, 5'b00010);
        r_lo = 1'b0;
        tick();
        chk("R10 pulse ends", take, 0);
        set_ie();
    endtask

    task automatic t_prio();
        trap = 1'b1; r_hi = 1'b1; r_mid = 1'b1; r_lo = 1'b1; gen = 1'b1;
        tick(); r_hi = 1'b0;
        pulse_bnd();
        chk("R3 trap first", src, 5'b10000);
        pulse_bnd();
        chk("R3 high second", src, 5'b01000);
        set_ie(); pulse_bnd();
        chk("R3 mid third", src, 5'b00100);
        r_mid = 1'b0; set_ie(); pulse_bnd();
        chk("R3 low fourth", src, 5'b00010);
        r_lo = 1'b0; set_ie(); pulse_bnd();
        chk("R3 general last ack", ack, 1);
        chk("R9 no take during ack", take, 0);
        opc = 8'hEF; tick();
        expect_take("R9 opcode 5", 16'h0028, 5'b00001);
        chk("R9 ack one cycle", ack, 0);
        chk("R8 general clears ie", ie, 0);
        gen = 1'b0; trap = 1'b0; set_ie();
    endtask

    task automatic t_general();
        gen = 1'b1; pulse_bnd();
        chk("R9 ack", ack, 1);
        opc = 8'hFF; tick();
        expect_take("R9 opcode 7", 16'h0038, 5'b00001);
        set_ie(); pulse_bnd();
        opc = 8'hC7; tick();
        expect_take("R9 opcode 0", 16'h0000, 5'b00001);
        pulse_bnd();
        chk("R7 general needs ie", ack, 0);
        gen = 1'b0; tick();
    endtask

    task automatic t_eidi();
        ei = 1'b1; di = 1'b1; tick(); ei = 1'b0; di = 1'b0;
        chk("R11 clear wins", ie, 0);
        set_ie();
        chk("R11 set", ie, 1);
        di = 1'b1; tick(); di = 1'b0;
        chk("R11 clear", ie, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_trap();
        t_vectors();
        t_edges_levels();
        t_mask();
        t_boundary();
        t_prio();
        t_general();
        t_eidi();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule